// File: doc/BRIEF.md
# Dual Host Transaction Request Queue

This block holds pending host transaction requests in two independent first-in first-out queues. One queue is for periodic traffic and one is for nonperiodic traffic. Software posts a request by pulsing a push strobe together with the entry fields. A downstream scheduler reads the head entry of each queue and pulses a pop strobe to consume it. Because of this, up to eight transactions of each kind can be scheduled well before they reach the bus.

Each side shows a read-only status view. It gives the number of free entries, whether the head entry is valid, and the head entry's direction token, channel number and request type. It also gives a sticky overflow flag. The view carries the free-space word of the matching transmit data FIFO, which is taken from an input port and passed through unchanged. Software must read the free count and see at least one free entry before it posts.

Each queue is run by a three-state machine:
- **Q_EMPTY**: nothing is stored and pop is ignored. Its transition is *accept* (a push goes to Q_PARTIAL).
- **Q_PARTIAL**: at least one entry is stored and at least one slot is free. Its transitions are *drain* (a pop of the last entry goes to Q_EMPTY) and *fill* (a push into the last free slot goes to Q_FULL). A push and a pop in the same cycle leave the state as it is (*swap*).
- **Q_FULL**: every slot is used. A push is refused and sets the overflow flag (*refuse*). A pop goes back to Q_PARTIAL (*release*).

Top module: `hreq_dual_queue`

## Requirements
- R1: After reset both queues are empty. Each free count reads 8, each head-valid reads 0 and each overflow flag reads 0.
- R2: The free count of a queue equals 8 minus the number of stored entries, and it always lies between 0 and 8.
- R3: An entry holds a token bit (1 = IN, 0 = OUT), a 4-bit channel number and a 2-bit request type. The head outputs show the oldest stored entry, and entries leave in the order they were pushed.
- R4: A push to a queue with at least one free entry is stored, and the free count drops by one in the cycle after the push.
- R5: The two queues are independent. A push or pop on one side leaves the other side's free count and head outputs unchanged.
- R6: A push to a full queue is dropped and leaves the stored entries unchanged. It sets that side's overflow flag, which stays set until reset.
- R7: A pop on an empty queue is ignored. Head-valid stays 0 and the free count stays 8.
- R8: A push and a pop in the same cycle are handled as follows. When the queue is partly filled, both take place and the free count is unchanged. When it is full, the pop takes place, the push is dropped and overflow is set. When it is empty, the push is stored and the pop is ignored.
- R9: Each side's transmit-FIFO free-space output equals its free-space input in the same cycle.
- R10: Eight periodic and eight nonperiodic requests can be pending at the same time, and both free counts then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_push | input | 1 | Post a periodic request |
| per_push_in | input | 1 | Token of posted periodic request (1 = IN) |
| per_push_chan | input | 4 | Channel of posted periodic request |
| per_push_kind | input | 2 | Request type of posted periodic request |
| per_pop | input | 1 | Scheduler consumes periodic head |
| per_head_valid | output | 1 | Periodic head entry present |
| per_head_in | output | 1 | Periodic head token |
| per_head_chan | output | 4 | Periodic head channel |
| per_head_kind | output | 2 | Periodic head request type |
| per_free | output | 4 | Free periodic entries (0 to 8) |
| per_overflow | output | 1 | Sticky: periodic push refused |
| per_txspace_in | input | 16 | Periodic transmit FIFO free space |
| per_txspace | output | 16 | Periodic transmit FIFO free space, passed through |
| np_push | input | 1 | Post a nonperiodic request |
| np_push_in | input | 1 | Token of posted nonperiodic request (1 = IN) |
| np_push_chan | input | 4 | Channel of posted nonperiodic request |
| np_push_kind | input | 2 | Request type of posted nonperiodic request |
| np_pop | input | 1 | Scheduler consumes nonperiodic head |
| np_head_valid | output | 1 | Nonperiodic head entry present |
| np_head_in | output | 1 | Nonperiodic head token |
| np_head_chan | output | 4 | Nonperiodic head channel |
| np_head_kind | output | 2 | Nonperiodic head request type |
| np_free | output | 4 | Free nonperiodic entries (0 to 8) |
| np_overflow | output | 1 | Sticky: nonperiodic push refused |
| np_txspace_in | input | 16 | Nonperiodic transmit FIFO free space |
| np_txspace | output | 16 | Nonperiodic transmit FIFO free space, passed through |

## Verification
A push from software and a pop from the scheduler can land on the same queue in the same cycle. The outcome then depends on whether the queue is empty, partly filled or full. The bench drives both strobes together in all three states. A scoreboard checks which entry left and whether the new one was kept, and the free count and overflow flag are compared one cycle later against a model that decides acceptance from the occupancy before the edge.

// File: rtl/hreq_pkg.sv
package hreq_pkg;
    localparam int CHAN_W = 4;
    localparam int KIND_W = 2;

    typedef struct packed {
        logic              is_in;
        logic [CHAN_W-1:0] chan;
        logic [KIND_W-1:0] kind;
    } hreq_entry_t;

    localparam int ENTRY_W = $bits(hreq_entry_t);

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL
    } qstate_e;
endpackage

// File: rtl/hreq_queue.sv
module hreq_queue
    import hreq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  hreq_entry_t      push_entry_i,
    input  logic             pop_i,
    output logic             head_valid_o,
    output hreq_entry_t      head_o,
    output logic [CNT_W-1:0] free_o,
    output logic             overflow_o
);
    localparam logic [CNT_W-1:0] CNT_DEPTH = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);

    qstate_e          state_q, state_d;
    logic [CNT_W-1:0] used_q, used_d;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             push_ok, pop_ok, refuse;
    hreq_entry_t      slots [DEPTH];

    // Acceptance decided by the current state
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        refuse  = 1'b0;
        unique case (state_q)
            Q_EMPTY: begin
                push_ok = push_i;
            end
            Q_PARTIAL: begin
                push_ok = push_i;
                pop_ok  = pop_i;
            end
            Q_FULL: begin
                pop_ok = pop_i;
                refuse = push_i;
            end
            default: begin
                push_ok = 1'b0;
            end
        endcase
    end

    // Next occupancy and next state
    always_comb begin
        used_d = used_q;
        if (push_ok && !pop_ok) used_d = used_q + CNT_W'(1);
        else if (!push_ok && pop_ok) used_d = used_q - CNT_W'(1);
        if (used_d == '0)             state_d = Q_EMPTY;
        else if (used_d == CNT_DEPTH) state_d = Q_FULL;
        else                          state_d = Q_PARTIAL;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= Q_EMPTY;
            used_q     <= '0;
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            overflow_o <= 1'b0;
        end else begin
            state_q <= state_d;
            used_q  <= used_d;
            if (push_ok) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PTR_W'(1);
            if (pop_ok)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + PTR_W'(1);
            if (refuse)  overflow_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr_q] <= push_entry_i;
    end

    // Outputs
    always_comb begin
        head_valid_o = (state_q != Q_EMPTY);
        head_o       = head_valid_o ? slots[rd_ptr_q] : '0;
        free_o       = CNT_DEPTH - used_q;
    end

    assert_free_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        free_o <= CNT_DEPTH);

    assert_push_takes_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && free_o != '0) |=> (free_o == $past(free_o) - CNT_W'(1)));

    assert_full_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && free_o == '0) |=> (free_o == '0 && overflow_o));

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid_o && pop_i && !push_i) |=> (free_o == CNT_DEPTH && !head_valid_o));

    assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && head_valid_o && free_o != '0) |=> $stable(free_o));
endmodule

// File: rtl/hreq_side_view.sv
module hreq_side_view
    import hreq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SPACE_W = 16
) (
    input  logic               head_valid_i,
    input  hreq_entry_t        head_i,
    input  logic [CNT_W-1:0]   free_i,
    input  logic               overflow_i,
    input  logic [SPACE_W-1:0] txspace_i,
    output logic               head_valid_o,
    output logic               head_in_o,
    output logic [CHAN_W-1:0]  head_chan_o,
    output logic [KIND_W-1:0]  head_kind_o,
    output logic [CNT_W-1:0]   free_o,
    output logic               overflow_o,
    output logic [SPACE_W-1:0] txspace_o
);
    always_comb begin
        head_valid_o = head_valid_i;
        head_in_o    = head_i.is_in;
        head_chan_o  = head_i.chan;
        head_kind_o  = head_i.kind;
        free_o       = free_i;
        overflow_o   = overflow_i;
        txspace_o    = txspace_i;
    end
endmodule

// File: rtl/hreq_dual_queue.sv
module hreq_dual_queue
    import hreq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int SPACE_W = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               per_push,
    input  logic               per_push_in,
    input  logic [CHAN_W-1:0]  per_push_chan,
    input  logic [KIND_W-1:0]  per_push_kind,
    input  logic               per_pop,
    output logic               per_head_valid,
    output logic               per_head_in,
    output logic [CHAN_W-1:0]  per_head_chan,
    output logic [KIND_W-1:0]  per_head_kind,
    output logic [CNT_W-1:0]   per_free,
    output logic               per_overflow,
    input  logic [SPACE_W-1:0] per_txspace_in,
    output logic [SPACE_W-1:0] per_txspace,
    input  logic               np_push,
    input  logic               np_push_in,
    input  logic [CHAN_W-1:0]  np_push_chan,
    input  logic [KIND_W-1:0]  np_push_kind,
    input  logic               np_pop,
    output logic               np_head_valid,
    output logic               np_head_in,
    output logic [CHAN_W-1:0]  np_head_chan,
    output logic [KIND_W-1:0]  np_head_kind,
    output logic [CNT_W-1:0]   np_free,
    output logic               np_overflow,
    input  logic [SPACE_W-1:0] np_txspace_in,
    output logic [SPACE_W-1:0] np_txspace
);
    localparam int SIDES = 2;

    logic               s_push  [SIDES];
    logic               s_pop   [SIDES];
    hreq_entry_t        s_entry [SIDES];
    logic [SPACE_W-1:0] s_space [SIDES];
    logic               q_hv    [SIDES];
    hreq_entry_t        q_head  [SIDES];
    logic [CNT_W-1:0]   q_free  [SIDES];
    logic               q_ovf   [SIDES];

    always_comb begin
        s_push[0]  = per_push;
        s_pop[0]   = per_pop;
        s_entry[0] = '{is_in: per_push_in, chan: per_push_chan, kind: per_push_kind};
        s_space[0] = per_txspace_in;
        s_push[1]  = np_push;
        s_pop[1]   = np_pop;
        s_entry[1] = '{is_in: np_push_in, chan: np_push_chan, kind: np_push_kind};
        s_space[1] = np_txspace_in;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        hreq_queue #(.DEPTH(DEPTH)) u_queue (
            .clk          (clk),
            .rst_n        (rst_n),
            .push_i       (s_push[s]),
            .push_entry_i (s_entry[s]),
            .pop_i        (s_pop[s]),
            .head_valid_o (q_hv[s]),
            .head_o       (q_head[s]),
            .free_o       (q_free[s]),
            .overflow_o   (q_ovf[s])
        );
    end

    hreq_side_view #(.CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_per_view (
        .head_valid_i (q_hv[0]),
        .head_i       (q_head[0]),
        .free_i       (q_free[0]),
        .overflow_i   (q_ovf[0]),
        .txspace_i    (s_space[0]),
        .head_valid_o (per_head_valid),
        .head_in_o    (per_head_in),
        .head_chan_o  (per_head_chan),
        .head_kind_o  (per_head_kind),
        .free_o       (per_free),
        .overflow_o   (per_overflow),
        .txspace_o    (per_txspace)
    );

    hreq_side_view #(.CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_np_view (
        .head_valid_i (q_hv[1]),
        .head_i       (q_head[1]),
        .free_i       (q_free[1]),
        .overflow_i   (q_ovf[1]),
        .txspace_i    (s_space[1]),
        .head_valid_o (np_head_valid),
        .head_in_o    (np_head_in),
        .head_chan_o  (np_head_chan),
        .head_kind_o  (np_head_kind),
        .free_o       (np_free),
        .overflow_o   (np_overflow),
        .txspace_o    (np_txspace)
    );

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (per_free == CNT_W'(DEPTH) && np_free == CNT_W'(DEPTH)
                    && !per_overflow && !np_overflow));

    assert_sides_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_push && !np_push && !np_pop) |=> $stable(np_free));
endmodule

// File: tb/hreq_dual_queue_bench.sv
module hreq_dual_queue_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       push_r [2];
    logic       pop_r  [2];
    logic       tok_r  [2];
    logic [3:0] ch_r   [2];
    logic [1:0] kd_r   [2];
    logic [15:0] sp_r  [2];

    logic       per_hv, per_hin, per_ovf, np_hv, np_hin, np_ovf;
    logic [3:0] per_hch, np_hch, per_free, np_free;
    logic [1:0] per_hkd, np_hkd;
    logic [15:0] per_sp, np_sp;

    hreq_dual_queue u_hreq_dual_queue (
        .clk(clk), .rst_n(rst_n),
        .per_push(push_r[0]), .per_push_in(tok_r[0]), .per_push_chan(ch_r[0]),
        .per_push_kind(kd_r[0]), .per_pop(pop_r[0]),
        .per_head_valid(per_hv), .per_head_in(per_hin), .per_head_chan(per_hch),
        .per_head_kind(per_hkd), .per_free(per_free), .per_overflow(per_ovf),
        .per_txspace_in(sp_r[0]), .per_txspace(per_sp),
        .np_push(push_r[1]), .np_push_in(tok_r[1]), .np_push_chan(ch_r[1]),
        .np_push_kind(kd_r[1]), .np_pop(pop_r[1]),
        .np_head_valid(np_hv), .np_head_in(np_hin), .np_head_chan(np_hch),
        .np_head_kind(np_hkd), .np_free(np_free), .np_overflow(np_ovf),
        .np_txspace_in(sp_r[1]), .np_txspace(np_sp)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0] exp_q0[$];
    logic [6:0] exp_q1[$];
    logic ovf_exp [2];

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Driver: posts a request and records the expected outcome
    task automatic post(input int s, input logic t, input logic [3:0] c, input logic [1:0] k);
        push_r[s] = 1'b1; tok_r[s] = t; ch_r[s] = c; kd_r[s] = k;
        if (s == 0) begin
            if (exp_q0.size() < 8) exp_q0.push_back({t, c, k}); else ovf_exp[0] = 1'b1;
        end else begin
            if (exp_q1.size() < 8) exp_q1.push_back({t, c, k}); else ovf_exp[1] = 1'b1;
        end
    endtask

    task automatic take(input int s);
        pop_r[s] = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        for (int s = 0; s < 2; s++) begin
            push_r[s] = 1'b0;
            pop_r[s]  = 1'b0;
        end
    endtask

    task automatic check_status(input string req);
        check({req, " per free"}, int'(per_free), 8 - exp_q0.size());
        check({req, " np free"},  int'(np_free),  8 - exp_q1.size());
        check({req, " per valid"}, int'(per_hv), int'(exp_q0.size() != 0));
        check({req, " np valid"},  int'(np_hv),  int'(exp_q1.size() != 0));
        check({req, " per ovf"}, int'(per_ovf), int'(ovf_exp[0]));
        check({req, " np ovf"},  int'(np_ovf),  int'(ovf_exp[1]));
    endtask

    // Monitor: compares each consumed head with the scoreboard (R3)
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n) begin
                if (pop_r[0] && per_hv) begin
                    if (exp_q0.size() == 0) check("R3 per unexpected head", 1, 0);
                    else check("R3 per head order", int'({per_hin, per_hch, per_hkd}),
                               int'(exp_q0.pop_front()));
                end
                if (pop_r[1] && np_hv) begin
                    if (exp_q1.size() == 0) check("R3 np unexpected head", 1, 0);
                    else check("R3 np head order", int'({np_hin, np_hch, np_hkd}),
                               int'(exp_q1.pop_front()));
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            push_r[s] = 1'b0; pop_r[s] = 1'b0; tok_r[s] = 1'b0;
            ch_r[s] = '0; kd_r[s] = '0; ovf_exp[s] = 1'b0;
        end
        sp_r[0] = 16'h0123; sp_r[1] = 16'h0ABC;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_status("R1 reset");

        // R9 pass-through, same cycle
        #1;
        check("R9 per space", int'(per_sp), 16'h0123);
        check("R9 np space", int'(np_sp), 16'h0ABC);
        sp_r[0] = 16'hFFFF; sp_r[1] = 16'h0000;
        #1;
        check("R9 per space change", int'(per_sp), 16'hFFFF);
        check("R9 np space change", int'(np_sp), 16'h0000);

        // R4/R5: three periodic posts, nonperiodic untouched
        post(0, 1'b1, 4'd3, 2'd0); tick();
        check("R4 free after one push", int'(per_free), 7);
        post(0, 1'b0, 4'd9, 2'd1); tick();
        post(0, 1'b1, 4'd15, 2'd2); tick();
        check_status("R4 R5 three posts");
        check("R5 np head idle", int'(np_hv), 0);
        check("R3 per head shows oldest", int'({per_hin, per_hch, per_hkd}), int'({1'b1, 4'd3, 2'd0}));

        // R3 drain in order
        for (int i = 0; i < 3; i++) begin take(0); tick(); end
        check_status("R3 drained");

        // R7 pop on empty
        take(0); take(1); tick();
        check_status("R7 empty pop");

        // R10 fill both sides
        for (int i = 0; i < 8; i++) begin
            post(0, i[0], 4'(i), 2'(i));
            post(1, ~i[0], 4'(15 - i), 2'(3 - (i % 4)));
            tick();
        end
        check_status("R10 both full");

        // R6 push to full
        post(0, 1'b1, 4'd1, 2'd3); tick();
        check_status("R6 refused push");

        // R8 full: pop taken, push dropped
        take(1); post(1, 1'b1, 4'd5, 2'd1); tick();
        check_status("R8 full swap");

        // R8 partial: both happen
        take(1); post(1, 1'b0, 4'd6, 2'd2); tick();
        check_status("R8 partial swap");

        // drain both
        for (int i = 0; i < 8; i++) begin take(0); take(1); tick(); end
        check_status("R3 R6 drained sticky");

        // R8 empty: push kept, pop ignored
        take(0); post(0, 1'b1, 4'd12, 2'd1); tick();
        check_status("R8 empty swap");
        check("R8 kept entry", int'({per_hin, per_hch, per_hkd}), int'({1'b1, 4'd12, 2'd1}));
        take(0); tick();
        check_status("R8 final drain");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule